// File: doc/BRIEF.md
# Conversion Result Threshold Monitor

This block watches the conversion results of a multi-channel converter as they are written into the result store. It looks only at the channel picked by its configuration word and compares each of that channel's results with a programmed threshold. The test is either "result below threshold" or "result at or above threshold". A counter tracks how many results in a row meet the test. Once that run reaches the programmed count plus one, a sticky compare flag is raised. An interrupt line follows the flag when interrupts are enabled.

Results arrive on a valid/ready stream. `res_ready` is always high, so the monitor never applies back-pressure, and each cycle with `res_valid` high carries exactly one result. The threshold word holds only its five most significant bits; the seven low bits are zero. Whether the threshold and the result are read as unsigned or as two's complement follows `fmt_signed`, the same format setting the converter uses. Several instances can run side by side, each with its own configuration word, to watch different thresholds.

Top module: `cmp_monitor`

## Requirements
- R1: After reset `cmp_flag` and `cmp_irq` are 0 and the match counter is empty.
- R2: A result takes part in the comparison only when `res_valid` is high, the enable bit (cfg bit 0) is 1 and `res_chan` equals the selected channel (cfg bits 5:3). Results for other channels neither advance nor reset the counter. While the enable bit is 0 the counter is held at zero.
- R3: With the condition bit (cfg bit 2) at 0, a result matches when it is strictly less than the threshold.
- R4: With the condition bit at 1, a result matches when it is greater than or equal to the threshold, equality included.
- R5: The threshold is the 12-bit value {cfg[27:23], 7'b0}.
- R6: When `fmt_signed` is 1, the result and the threshold are compared as 12-bit two's complement numbers. When it is 0 they are compared unsigned.
- R7: Each match increments the counter. The flag is set on the clock edge that accepts match number cfg[11:8]+1 in a row, and the counter then returns to zero. A result for the selected channel that fails the test resets the counter to zero.
- R8: The flag stays set until `flag_clr` is high at a clock edge. That edge clears both the flag and the counter, and a result accepted on the same edge is discarded.
- R9: `cmp_irq` is 1 exactly when `cmp_flag` is 1 and the interrupt enable bit (cfg bit 1) is 1.
- R10: Channel code 4 is reserved and never yields a match. Code 5 (pre-amplifier source) and codes 0-3, 6 and 7 are monitored in the normal way.
- R11: `res_ready` is always 1, so every valid result is accepted in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A conversion result is presented |
| res_ready | output | 1 | Always 1; the monitor never stalls |
| res_chan | input | 3 | Channel code of the presented result |
| res_data | input | 12 | Conversion result |
| fmt_signed | input | 1 | 1: two's complement results, 0: unsigned |
| cfg_word | input | 32 | Configuration: enable, interrupt enable, condition, channel, match count, threshold |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| cmp_flag | output | 1 | Sticky compare flag |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
The comparison is driven with results one code below the threshold and exactly at it, under both conditions. This separates a strict test from an inclusive one and checks that the threshold's seven low bits are zero. Runs of matches are broken by a failing result on the watched channel and padded with results on other channels, which shows that only a failure resets the count. The same negative sample is compared with `fmt_signed` set and cleared, which tells signed ordering from unsigned. The reserved channel code, the pre-amplifier code, a disabled monitor and the interrupt enable are each tried against the same matching data, so that any flag or interrupt change can be traced to that one setting.

// File: rtl/cmpmon_pkg.sv
package cmpmon_pkg;
  localparam int CH_W   = 3;
  localparam int CNT_W  = 4;
  localparam int THR_W  = 5;
  localparam int DATA_W = 12;

  typedef enum logic {
    COND_BELOW = 1'b0,
    COND_AT_OR_ABOVE = 1'b1
  } cond_e;

  typedef struct packed {
    logic             en;
    logic             ie;
    cond_e            cond;
    logic [CH_W-1:0]  chan;
    logic [CNT_W-1:0] limit;
    logic [THR_W-1:0] thr;
  } cfg_t;
endpackage

// File: rtl/cmpmon_cfg_decode.sv
module cmpmon_cfg_decode
  import cmpmon_pkg::*;
(
  input  logic [31:0] cfg_word,
  output cfg_t        cfg
);
  // field positions are shared with the register block that drives cfg_word
  localparam int EN_BIT   = 0;
  localparam int IE_BIT   = 1;
  localparam int COND_BIT = 2;
  localparam int CH_LO    = 3;
  localparam int CNT_LO   = 8;
  localparam int THR_LO   = 23;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_word[7:6], cfg_word[22:12], cfg_word[31:28]};

  always_comb begin
    cfg.en    = cfg_word[EN_BIT];
    cfg.ie    = cfg_word[IE_BIT];
    cfg.cond  = cond_e'(cfg_word[COND_BIT]);
    cfg.chan  = cfg_word[CH_LO +: CH_W];
    cfg.limit = cfg_word[CNT_LO +: CNT_W];
    cfg.thr   = cfg_word[THR_LO +: THR_W];
  end
endmodule

// File: rtl/cmpmon_compare.sv
module cmpmon_compare
  import cmpmon_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int TW = THR_W
) (
  input  logic [DW-1:0] data,
  input  logic [TW-1:0] thr,
  input  logic          signed_fmt,
  input  cond_e         cond,
  output logic          hit
);
  localparam int LOW_W = DW - TW;

  logic [DW-1:0] thr_full;
  logic          below;

  assign thr_full = {thr, {LOW_W{1'b0}}};

  always_comb begin
    if (signed_fmt) below = $signed(data) < $signed(thr_full);
    else            below = data < thr_full;
    hit = (cond == COND_AT_OR_ABOVE) ? !below : below;
  end
endmodule

// File: rtl/cmpmon_match_ctr.sv
module cmpmon_match_ctr #(
  parameter int CW = cmpmon_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          enable,
  input  logic          sample,
  input  logic          hit,
  input  logic [CW-1:0] limit,
  output logic          flag
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else if (!enable) begin
      cnt  <= '0;
    end else if (sample) begin
      if (!hit) begin
        cnt <= '0;
      end else if (cnt >= limit) begin
        cnt  <= '0;
        flag <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr |=> flag);
  p_clr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !flag);
  p_needs_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && !sample |=> !flag);
  p_miss_no_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && sample && !hit |=> !flag);
  p_first_of_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag && sample && hit && cnt == '0 && limit != '0 |=> !flag);
endmodule

// File: rtl/cmp_monitor.sv
module cmp_monitor
  import cmpmon_pkg::*;
#(
  parameter int RSV_CODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic              fmt_signed,
  input  logic [31:0]       cfg_word,
  input  logic              flag_clr,
  output logic              cmp_flag,
  output logic              cmp_irq
);
  localparam logic [CH_W-1:0] RSV = CH_W'(RSV_CODE);

  cfg_t cfg;
  logic hit;
  logic take;

  cmpmon_cfg_decode u_dec (
    .cfg_word (cfg_word),
    .cfg      (cfg)
  );

  cmpmon_compare #(.DW(DATA_W), .TW(THR_W)) u_cmp (
    .data       (res_data),
    .thr        (cfg.thr),
    .signed_fmt (fmt_signed),
    .cond       (cfg.cond),
    .hit        (hit)
  );

  assign res_ready = 1'b1;
  assign take = res_valid && res_ready && (res_chan == cfg.chan) && (cfg.chan != RSV);

  cmpmon_match_ctr #(.CW(CNT_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (flag_clr),
    .enable (cfg.en),
    .sample (take),
    .hit    (hit),
    .limit  (cfg.limit),
    .flag   (cmp_flag)
  );

  assign cmp_irq = cmp_flag & cfg.ie;

  p_rsv_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_flag && cfg.chan == RSV |=> !cmp_flag);
  p_off_no_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_flag && !cfg.en |=> !cmp_flag);
  p_irq_needs_ie_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> cfg.ie && cmp_flag);
endmodule

// File: tb/cmp_monitor_tb.sv
module cmp_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [2:0]  res_chan = '0;
  logic [11:0] res_data = '0;
  logic        fmt_signed = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        flag_clr = 1'b0;
  logic        cmp_flag;
  logic        cmp_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  flag;
    logic  irq;
    string tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic       m_en = 0, m_ie = 0, m_cond = 0, m_fmt = 0;
  logic [2:0] m_ch = 0;
  logic [3:0] m_lim = 0;
  logic [4:0] m_thr = 0;
  int         m_cnt = 0;
  logic       m_flag = 0;

  always #5 clk = ~clk;

  cmp_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_chan(res_chan), .res_data(res_data), .fmt_signed(fmt_signed),
    .cfg_word(cfg_word), .flag_clr(flag_clr), .cmp_flag(cmp_flag), .cmp_irq(cmp_irq)
  );

  function automatic logic ref_hit(input logic [11:0] d);
    int dv, tv;
    logic [11:0] t;
    t = {m_thr, 7'b0};
    dv = m_fmt ? int'($signed(d)) : int'(d);
    tv = m_fmt ? int'($signed(t)) : int'(t);
    return m_cond ? (dv >= tv) : (dv < tv);
  endfunction

  task automatic set_cfg(input logic en, ie, cond, input logic [2:0] ch,
                         input logic [3:0] lim, input logic [4:0] thr, input logic fmt);
    @(negedge clk); #1;
    m_en = en; m_ie = ie; m_cond = cond; m_ch = ch; m_lim = lim; m_thr = thr; m_fmt = fmt;
    cfg_word = '0;
    cfg_word[0] = en; cfg_word[1] = ie; cfg_word[2] = cond;
    cfg_word[5:3] = ch; cfg_word[11:8] = lim; cfg_word[27:23] = thr;
    fmt_signed = fmt;
  endtask

  task automatic step(input logic v, input logic [2:0] ch, input logic [11:0] d,
                      input logic clr, input string tag);
    exp_t e;
    @(negedge clk); #1;
    res_valid = v; res_chan = ch; res_data = d; flag_clr = clr;
    @(posedge clk); #1;
    if (clr) begin
      m_flag = 0; m_cnt = 0;
    end else if (!m_en) begin
      m_cnt = 0;
    end else if (v && ch == m_ch && m_ch != 3'd4) begin
      if (!ref_hit(d)) m_cnt = 0;
      else if (m_cnt >= int'(m_lim)) begin m_cnt = 0; m_flag = 1; end
      else m_cnt++;
    end
    res_valid = 0; flag_clr = 0;
    e.flag = m_flag; e.irq = m_flag & m_ie; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops one expected item per result cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (cmp_flag !== e.flag || cmp_irq !== e.irq) begin
        errors++;
        $display("FAIL %s flag/irq actual %b/%b expected %b/%b", e.tag, cmp_flag, cmp_irq, e.flag, e.irq);
      end
      checks++;
      if (res_ready !== 1'b1) begin
        errors++;
        $display("FAIL R11 res_ready actual %b expected 1", res_ready);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 0, "R1 reset state");

    // R3/R5: below 0x800, unsigned, single match
    set_cfg(1, 0, 0, 3'd2, 4'd0, 5'h10, 0);
    step(1, 3'd2, 12'h800, 0, "R5 equal is not below");
    step(1, 3'd2, 12'h7FF, 0, "R3 one below threshold sets flag");
    step(1, 3'd2, 12'hFFF, 0, "R8 flag sticky after failing result");
    step(0, 0, 0, 1, "R8 clear drops flag");

    // R4/R7/R2: at-or-above, three in a row, other channel in between
    set_cfg(1, 0, 1, 3'd2, 4'd2, 5'h10, 0);
    step(1, 3'd2, 12'h800, 0, "R4 equality matches, run 1");
    step(1, 3'd2, 12'h900, 0, "R7 run 2 no flag yet");
    step(1, 3'd1, 12'h000, 0, "R2 other channel ignored");
    step(1, 3'd2, 12'hFFF, 0, "R7 run 3 sets flag");
    step(0, 0, 0, 1, "R8 clear");

    // R7: failing result restarts the run
    step(1, 3'd2, 12'h800, 0, "R7 run 1");
    step(1, 3'd2, 12'h800, 0, "R7 run 2");
    step(1, 3'd2, 12'h7FF, 0, "R7 miss resets counter");
    step(1, 3'd2, 12'h800, 0, "R7 restart 1");
    step(1, 3'd2, 12'h800, 0, "R7 restart 2");
    step(1, 3'd2, 12'h800, 0, "R7 restart 3 sets flag");

    // R9: interrupt enable gates the flag
    set_cfg(1, 1, 1, 3'd2, 4'd2, 5'h10, 0);
    step(0, 0, 0, 0, "R9 irq follows flag with ie");
    set_cfg(1, 0, 1, 3'd2, 4'd2, 5'h10, 0);
    step(0, 0, 0, 0, "R9 irq low without ie");

    // R8: clear on same edge as a match discards it
    set_cfg(1, 1, 1, 3'd2, 4'd0, 5'h10, 0);
    step(1, 3'd2, 12'hA00, 1, "R8 clear wins over match");

    // R2: disabled monitor
    set_cfg(0, 1, 1, 3'd2, 4'd0, 5'h10, 0);
    step(1, 3'd2, 12'hA00, 0, "R2 disabled no flag");
    step(1, 3'd2, 12'hA00, 0, "R2 disabled no flag again");

    // R10: reserved code and pre-amplifier code
    set_cfg(1, 1, 1, 3'd4, 4'd0, 5'h00, 0);
    step(1, 3'd4, 12'hFFF, 0, "R10 reserved code never matches");
    set_cfg(1, 1, 1, 3'd5, 4'd0, 5'h00, 0);
    step(1, 3'd5, 12'h001, 0, "R10 amplifier code monitored");
    step(0, 0, 0, 1, "R8 clear");

    // R6: signed vs unsigned ordering of 0xFFF against 0
    set_cfg(1, 0, 0, 3'd7, 4'd0, 5'h00, 0);
    step(1, 3'd7, 12'hFFF, 0, "R6 unsigned 0xFFF not below 0");
    set_cfg(1, 0, 0, 3'd7, 4'd0, 5'h00, 1);
    step(1, 3'd7, 12'h001, 0, "R6 signed +1 not below 0");
    step(1, 3'd7, 12'hFFF, 0, "R6 signed -1 below 0 sets flag");
    step(0, 0, 0, 1, "R8 clear");
    set_cfg(1, 0, 1, 3'd7, 4'd0, 5'h10, 1);
    step(1, 3'd7, 12'h000, 0, "R6 signed 0 at or above -2048");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule